// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port. One byte at a time moves over a single data line, and the port drives a shift clock out on a second line. Timing is counted in machine cycles. The surrounding system supplies two strobes for each machine cycle: `mc_tick` marks the boundary between machine cycles, and `mc_mid` marks the middle of each one.

A transmit begins when a byte is written into the buffer. That byte goes into a nine-bit shift register, with a set marker bit above it. The end of the transfer is found by watching that marker move down the register, so no bit counter is needed. A receive begins when the receive enable is high and the receive-done flag is clear. The receive register is preset with all ones and a single zero marker in the lowest position. When the zero reaches the top position, one last shift is made and the byte is placed in the receive buffer. Software clears each completion flag with a one-cycle clear strobe.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, `tx_done`, `rx_done`, `send_act`, `recv_act` and `sdat_oe` are 0, and `sclk_o` and `sdat_o` are 1.
- R2: An accepted buffer write is transmitted least significant bit first on `sdat_o`, one bit per machine cycle, with `sdat_oe` high while `send_act` is high.
- R3: Counting the `mc_tick` edges after the write, `send_act` rises on the 2nd edge. It stays high for DATA_W machine cycles and falls on edge DATA_W+2 (the 10th for a byte), and `tx_done` is set on that same edge.
- R4: While a transfer is active, `sclk_o` goes low on each `mc_tick` edge and goes high on each `mc_mid` edge. When no transfer is active it stays high.
- R5: A buffer write is ignored while a transmit or receive is pending or active. The byte on the line, the completion edge and the flags are unchanged by it.
- R6: With `rx_en` high, `rx_done` low and no transfer pending, `recv_act` rises on the 2nd `mc_tick` edge after the request is seen. It falls on edge DATA_W+2, and `rx_done` is set on that same edge.
- R7: The receiver samples `sdat_i` on each `mc_mid` edge (the rising edge of the shift clock) during reception. The first sampled bit becomes bit 0 of `rx_buf`.
- R8: A completion flag stays set until its clear strobe is pulsed. While `rx_done` is 1, no new reception starts, even with `rx_en` held high.
- R9: A reception does not start while a transmit is pending or active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick | input | 1 | Machine-cycle boundary strobe |
| mc_mid | input | 1 | Mid machine-cycle strobe |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | DATA_W | Byte to transmit |
| rx_en | input | 1 | Receive enable |
| tx_flag_clr | input | 1 | Clears tx_done |
| rx_flag_clr | input | 1 | Clears rx_done |
| sdat_i | input | 1 | Data line input |
| sdat_o | output | 1 | Data line output value |
| sdat_oe | output | 1 | Data line output enable |
| sclk_o | output | 1 | Shift clock output |
| send_act | output | 1 | Transmit shifting active |
| recv_act | output | 1 | Receive shifting active |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| rx_buf | output | DATA_W | Last received byte |

## Verification
The bench builds the port with DATA_W=8, LAUNCH_TICKS=2 and RX_LSB_FIRST=1. This is the byte-wide case, and it makes the completion edge land on the tenth machine-cycle boundary after the start. The marker test, the one-cycle launch delay and the bit order are all checked against that fixed offset. With the short launch delay, a write or a receive request can be placed both during the pending window and during active shifting. This exercises the rules that ignore such requests and the rules that keep the two directions apart.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   localparam int unsigned SSP_MIN_DATA_W = 2;

   typedef enum logic {
      SCK_HIGH = 1'b0,
      SCK_LOW  = 1'b1
   } sck_phase_e;
endpackage

// File: rtl/ssp_launch.sv
// Delays a start request by a fixed number of machine-cycle boundaries.
module ssp_launch #(
   parameter int unsigned TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic req,
   output logic busy,
   output logic fire
);
   localparam int unsigned CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);

   if (TICKS < 1) begin : g_bad_ticks
      $error("ssp_launch: TICKS must be at least 1");
   end

   logic          pend_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!pend_q) begin
         if (req) begin
            pend_q <= 1'b1;
            cnt_q  <= '0;
         end
      end else if (tick) begin
         if (cnt_q == CW'(TICKS - 1)) pend_q <= 1'b0;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign busy = pend_q;
   assign fire = pend_q && tick && (cnt_q == CW'(TICKS - 1));

   AST_LAUNCH_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q) |-> $past(tick)); // R3
endmodule

// File: rtl/ssp_tx.sv
// Transmit shifter: marker bit above the data, zeros fill from the left.
module ssp_tx #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic              load,
   input  logic [DATA_W-1:0] ldata,
   output logic              send,
   output logic              bit_o,
   output logic              done_set
);
   localparam int unsigned SW = DATA_W + 1;

   logic [SW-1:0] sh_q;
   logic          at_end;

   // final shift pending: marker just above output, all higher bits zero
   assign at_end = (sh_q[SW-1:1] == (SW-1)'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
         send <= 1'b0;
      end else if (load) begin
         sh_q <= {1'b1, ldata};
      end else if (tick) begin
         if (start) begin
            send <= 1'b1;
         end else if (send) begin
            sh_q <= {1'b0, sh_q[SW-1:1]};
            if (at_end) send <= 1'b0;
         end
      end
   end

   assign bit_o    = sh_q[0];
   assign done_set = send && tick && at_end;

   AST_TX_MARKER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      send |-> (sh_q[SW-1:1] != '0)); // R3
   AST_TX_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (send && tick && !at_end) |=> (sh_q[SW-1] == 1'b0)); // R2
endmodule

// File: rtl/ssp_rx.sv
// Receive shifter: ones preset with a zero marker, data enters on the right.
module ssp_rx #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              mid,
   input  logic              start,
   input  logic              din,
   output logic              act,
   output logic              done_set,
   output logic [DATA_W-1:0] data
);
   logic [DATA_W-1:0] sh_q;
   logic              samp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         samp_q <= 1'b1;
         act    <= 1'b0;
      end else begin
         if (mid && act) samp_q <= din;
         if (tick) begin
            if (start) begin
               sh_q <= {{(DATA_W-1){1'b1}}, 1'b0};
               act  <= 1'b1;
            end else if (act) begin
               sh_q <= {sh_q[DATA_W-2:0], samp_q};
               if (!sh_q[DATA_W-1]) act <= 1'b0;
            end
         end
      end
   end

   assign done_set = act && tick && !sh_q[DATA_W-1];
   assign data     = {sh_q[DATA_W-2:0], samp_q};

   AST_RX_MARKER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      act |-> !(&sh_q)); // R6
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned LAUNCH_TICKS = 2,
   parameter bit          RX_LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mc_tick,
   input  logic              mc_mid,
   input  logic              buf_wr,
   input  logic [DATA_W-1:0] buf_wdata,
   input  logic              rx_en,
   input  logic              tx_flag_clr,
   input  logic              rx_flag_clr,
   input  logic              sdat_i,
   output logic              sdat_o,
   output logic              sdat_oe,
   output logic              sclk_o,
   output logic              send_act,
   output logic              recv_act,
   output logic              tx_done,
   output logic              rx_done,
   output logic [DATA_W-1:0] rx_buf
);
   import ssp_pkg::*;

   if (DATA_W < SSP_MIN_DATA_W) begin : g_bad_width
      $error("sync_shift_port: DATA_W too small");
   end

   logic tx_pend, tx_fire, tx_bit, tx_set;
   logic rx_pend, rx_fire, rx_set;
   logic tx_busy, rx_busy, wr_ok, rx_req;
   logic [DATA_W-1:0] rx_raw, rx_ord;
   sck_phase_e        sck_ph;

   assign tx_busy = tx_pend | send_act;
   assign rx_busy = rx_pend | recv_act;
   assign wr_ok   = buf_wr && !tx_busy && !rx_busy;
   assign rx_req  = rx_en && !rx_done && !tx_busy && !rx_busy && !buf_wr;

   ssp_launch #(.TICKS(LAUNCH_TICKS)) u_tx_launch (
      .clk(clk), .rst_n(rst_n), .tick(mc_tick), .req(wr_ok),
      .busy(tx_pend), .fire(tx_fire));

   ssp_launch #(.TICKS(LAUNCH_TICKS)) u_rx_launch (
      .clk(clk), .rst_n(rst_n), .tick(mc_tick), .req(rx_req),
      .busy(rx_pend), .fire(rx_fire));

   ssp_tx #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(mc_tick), .start(tx_fire),
      .load(wr_ok), .ldata(buf_wdata), .send(send_act), .bit_o(tx_bit),
      .done_set(tx_set));

   ssp_rx #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(mc_tick), .mid(mc_mid),
      .start(rx_fire), .din(sdat_i), .act(recv_act), .done_set(rx_set),
      .data(rx_raw));

   // first bit in lands on the left; optionally flip so it becomes bit 0
   if (RX_LSB_FIRST) begin : g_rx_flip
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign rx_ord[i] = rx_raw[DATA_W-1-i];
      end
   end else begin : g_rx_keep
      assign rx_ord = rx_raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_done <= 1'b0;
         rx_done <= 1'b0;
         rx_buf  <= '0;
         sck_ph  <= SCK_HIGH;
      end else begin
         if (tx_set)           tx_done <= 1'b1;
         else if (tx_flag_clr) tx_done <= 1'b0;
         if (rx_set) begin
            rx_done <= 1'b1;
            rx_buf  <= rx_ord;
         end else if (rx_flag_clr) begin
            rx_done <= 1'b0;
         end
         if (mc_tick)     sck_ph <= SCK_LOW;
         else if (mc_mid) sck_ph <= SCK_HIGH;
      end
   end

   assign sclk_o  = !((sck_ph == SCK_LOW) && (send_act || recv_act));
   assign sdat_oe = send_act;
   assign sdat_o  = send_act ? tx_bit : 1'b1;

   AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n)
      !(send_act && recv_act)); // R9
   AST_SCLK_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk_o) |-> $past(mc_tick)); // R4
   AST_TX_DONE_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> $past(send_act)); // R3
   AST_RX_DONE_AFTER_RECV: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_done) |-> $past(recv_act)); // R6
   AST_RX_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !rx_flag_clr && !recv_act) |=> !recv_act); // R8
endmodule

// File: tb/test_sync_shift_port.sv
module test_sync_shift_port;
   localparam int DW     = 8;
   localparam int MC_LEN = 6;

   logic clk = 1'b0;
   logic rst_n;
   logic mc_tick, mc_mid;
   logic buf_wr;
   logic [DW-1:0] buf_wdata;
   logic rx_en, tx_flag_clr, rx_flag_clr, sdat_i;
   logic sdat_o, sdat_oe, sclk_o, send_act, recv_act, tx_done, rx_done;
   logic [DW-1:0] rx_buf;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   sync_shift_port #(.DATA_W(DW), .LAUNCH_TICKS(2), .RX_LSB_FIRST(1'b1)) i_sync_shift_port (
      .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .mc_mid(mc_mid),
      .buf_wr(buf_wr), .buf_wdata(buf_wdata), .rx_en(rx_en),
      .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr), .sdat_i(sdat_i),
      .sdat_o(sdat_o), .sdat_oe(sdat_oe), .sclk_o(sclk_o),
      .send_act(send_act), .recv_act(recv_act), .tx_done(tx_done),
      .rx_done(rx_done), .rx_buf(rx_buf));

   // machine-cycle strobes
   initial begin
      int ph;
      ph = 0;
      mc_tick = 1'b0;
      mc_mid  = 1'b0;
      forever begin
         @(negedge clk);
         ph = (ph + 1) % MC_LEN;
         mc_tick = (ph == 0);
         mc_mid  = (ph == 3);
      end
   end

   function automatic logic exp_line_bit(input logic [DW-1:0] d, input int j);
      return d[j];
   endfunction

   function automatic logic [DW-1:0] exp_rx_byte(input logic [DW-1:0] bits_in_order);
      return bits_in_order; // bit j is the j-th bit sent on the line
   endfunction

   task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", rq, got, exp);
      end
   endtask

   task automatic wait_tick();
      do @(posedge clk); while (mc_tick !== 1'b1);
   endtask

   task automatic next_tick_sample();
      wait_tick();
      @(negedge clk);
   endtask

   // transmit one byte; inj: extra writes that must be ignored; rx_poke: raise rx_en during send
   task automatic tx_run(input logic [DW-1:0] d, input bit inj, input bit rx_poke);
      next_tick_sample();
      buf_wr = 1'b1; buf_wdata = d;
      @(negedge clk);
      buf_wr = 1'b0;
      next_tick_sample();                       // tick 1
      chk("R3 send not yet", send_act, 0);
      if (inj) begin
         buf_wr = 1'b1; buf_wdata = ~d;
         @(negedge clk);
         buf_wr = 1'b0;
      end
      for (int j = 0; j < DW; j++) begin
         next_tick_sample();                    // tick 2+j
         chk("R3 send active", send_act, 1);
         chk("R2 line bit", sdat_o, exp_line_bit(d, j));
         chk("R2 output enable", sdat_oe, 1);
         chk("R4 sclk low phase", sclk_o, 0);
         if (rx_poke) begin
            chk("R9 no receive during send", recv_act, 0);
            if (j == 1) rx_en = 1'b1;
            if (j == 6) rx_en = 1'b0;
         end
         if (inj && j == 3) begin
            buf_wr = 1'b1; buf_wdata = ~d;
         end
         @(negedge clk);
         buf_wr = 1'b0;
         @(negedge clk);
         @(negedge clk);
         chk("R4 sclk high phase", sclk_o, 1);
      end
      next_tick_sample();                       // tick DW+2
      chk("R3 send dropped", send_act, 0);
      chk("R3 tx_done set", tx_done, 1);
      chk("R4 sclk idle", sclk_o, 1);
      chk("R2 oe released", sdat_oe, 0);
      for (int k = 0; k < 3; k++) begin
         next_tick_sample();
         chk("R8 tx_done held", tx_done, 1);
         chk("R5 no second send", send_act, 0);
         if (rx_poke) chk("R9 no late receive", recv_act, 0);
      end
      tx_flag_clr = 1'b1;
      @(negedge clk);
      tx_flag_clr = 1'b0;
      chk("R8 tx_done cleared", tx_done, 0);
   endtask

   task automatic rx_run(input logic [DW-1:0] b, input bit inj);
      next_tick_sample();
      rx_en = 1'b1;
      next_tick_sample();                       // tick 1
      chk("R6 receive not yet", recv_act, 0);
      for (int j = 0; j < DW; j++) begin
         next_tick_sample();                    // tick 2+j
         chk("R6 receive active", recv_act, 1);
         chk("R4 sclk low in receive", sclk_o, 0);
         chk("R2 line not driven in receive", sdat_oe, 0);
         sdat_i = b[j];
         if (inj && j == 4) buf_wr = 1'b1;
         @(negedge clk);
         buf_wr = 1'b0;
      end
      next_tick_sample();                       // tick DW+2
      chk("R6 receive ended", recv_act, 0);
      chk("R6 rx_done set", rx_done, 1);
      chk("R7 received byte", rx_buf, exp_rx_byte(b));
      for (int k = 0; k < 3; k++) begin
         next_tick_sample();
         chk("R8 no restart while rx_done", recv_act, 0);
         chk("R8 rx_buf kept", rx_buf, exp_rx_byte(b));
         if (inj) begin
            chk("R5 write during receive ignored", send_act, 0);
            chk("R5 no tx_done", tx_done, 0);
         end
      end
      rx_en = 1'b0;
      rx_flag_clr = 1'b1;
      @(negedge clk);
      rx_flag_clr = 1'b0;
      chk("R8 rx_done cleared", rx_done, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 32'h5EED;
      void'($urandom(seed));
      rst_n = 1'b0; buf_wr = 1'b0; buf_wdata = '0; rx_en = 1'b0;
      tx_flag_clr = 1'b0; rx_flag_clr = 1'b0; sdat_i = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 tx_done reset", tx_done, 0);
      chk("R1 rx_done reset", rx_done, 0);
      chk("R1 send reset", send_act, 0);
      chk("R1 recv reset", recv_act, 0);
      chk("R1 oe reset", sdat_oe, 0);
      chk("R1 sclk reset", sclk_o, 1);
      chk("R1 line reset", sdat_o, 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      tx_run(8'h00, 1'b0, 1'b0);
      tx_run(8'hFF, 1'b0, 1'b0);
      tx_run(8'h80, 1'b1, 1'b0);   // R5 writes while pending and sending
      tx_run(8'hA5, 1'b0, 1'b1);   // R9 receive request during send
      rx_run(8'h01, 1'b0);
      rx_run(8'hFE, 1'b1);         // R5 write during receive
      for (int i = 0; i < 12; i++) begin
         tx_run(DW'($urandom), 1'b0, 1'b0);
         rx_run(DW'($urandom), 1'b0);
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule